// File: doc/BRIEF.md
# Rail Fault Supervisor with Latched Shutdown

This block supervises the protection policy of a multi-rail panel power controller. Analog comparators outside the block report each rail's condition as plain digital flags. The rails are the boost main rail, the I/O buck, the core buck and the positive and negative gate-drive pumps. Other comparators report the isolation-switch drop, die over-temperature and the input supply. From these flags the supervisor drives one enable per converter and one for the isolation switch. It also keeps a latched global shutdown with a sticky cause vector, and selects a switching-frequency divider for the I/O buck.

All timing comes from a shared timebase strobe, `tick`. Long persistence windows (nominally 50 ms) guard the rail under-level faults and the core-buck overcurrent restart. A short window (nominally 200 µs) guards the isolation-switch drop. A persistence counter restarts whenever its flag drops before the window ends. Once latched, the shutdown survives everything except a deep supply collapse (`deep_rst`). Over-temperature only pauses switching and recovers by itself.

Top module: `rail_fault_sup`

## Requirements
- R1: While `rst_n` is low, all six enables, `shutdown`, `fault_cause` and `io_fdiv` are zero. No enable rises until the supply has been seen good (`uv` low) once. One clock after that, with no flags set, all enables are 1.
- R2: A boost under-level (`boost_low`), positive gate under-level (`gh_low`) or negative gate over-level (`gl_high`) flag clears only that rail's enable on the next clock. The enable returns on the next clock after the flag clears. `io_low` and `core_low` never clear an enable.
- R3: Each of the five under-level flags owns a persistence counter. When the flag is held high through LONG_TICKS tick strobes, `shutdown` sets and a cause bit sets: bit 0 boost, 1 I/O, 2 core, 3 positive gate, 4 negative gate. A clock with the flag low restarts that counter.
- R4: When `iso_over` is high and `iso_code` is not zero, `en_boost` and `en_iso` clear on the next clock. After SHORT_TICKS strobes, `shutdown` latches with cause bit 5. With `iso_code` equal to 0, `iso_over` has no effect.
- R5: `uv` high latches `shutdown` with cause bit 6, but only once the supply has been armed. The supply arms when `uv` is seen low after reset or after `deep_rst`. Before arming, `uv` causes no latch.
- R6: `shutdown` and `fault_cause` hold after the causing flag clears. The only release is `deep_rst`, which clears both on the next clock.
- R7: `hot` clears every converter enable (boost, I/O, core, both gate rails) on the next clock. `en_iso` stays set. No latch or cause bit results, however long `hot` lasts, and the enables return on the clock after `hot` falls.
- R8: `io_fdiv` is 2'b10 (quarter rate) when `io_short` is high. Otherwise it is 2'b01 (half rate) when `io_low` is high, and 2'b00 (full rate) when neither is set. It is registered one clock behind its inputs.
- R9: `core_short` clears `en_core` on the next clock without any latch, and `en_core` returns on the clock after it clears.
- R10: OC_CYCLES consecutive `sw_cycle` strobes that carry `core_oc` clear `en_core` on that clock, and it stays clear for LONG_TICKS strobes. A strobe without `core_oc` restarts the run.
- R11: While `shutdown` is set, all six enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared timebase strobe, one clock wide |
| boost_low | input | 1 | Boost rail below 80 % |
| io_low | input | 1 | I/O buck below 80 % |
| io_short | input | 1 | I/O buck below 20 % |
| core_low | input | 1 | Core buck below 80 % |
| core_short | input | 1 | Core buck below 20 % |
| gh_low | input | 1 | Positive gate rail below 75 % |
| gl_high | input | 1 | Negative gate rail above target by the fault margin |
| iso_over | input | 1 | Isolation-switch drop above programmed threshold |
| iso_code | input | CODE_W | Isolation threshold code, 0 disables the check |
| core_oc | input | 1 | Core buck overcurrent in the current switching cycle |
| sw_cycle | input | 1 | Core buck switching-cycle strobe |
| hot | input | 1 | Die over-temperature (hysteresis in the comparator) |
| uv | input | 1 | Supply undervoltage (hysteresis in the comparator) |
| deep_rst | input | 1 | Supply below deep-reset level |
| en_boost | output | 1 | Boost converter enable |
| en_iso | output | 1 | Isolation switch enable |
| en_io | output | 1 | I/O buck enable |
| en_core | output | 1 | Core buck enable |
| en_gh | output | 1 | Positive gate pump enable |
| en_gl | output | 1 | Negative gate pump enable |
| io_fdiv | output | 2 | I/O buck frequency divider code |
| shutdown | output | 1 | Latched global shutdown |
| fault_cause | output | 7 | Sticky cause bits of the latch |

## Verification
The bench sweeps the hold length of every persistence window, one strobe short and exactly at the limit. A counter that is off by one would latch a strobe early or late. A counter that is not restarted by a flag dropout would latch after the combined time. All sixteen isolation threshold codes are walked, so a design that forgot the code-zero bypass would latch at code 0. The supply sequence is tested both before and after arming, which catches a design that latches during power-up. Over-temperature is held beyond the long window, so a supervisor that latched it would be caught. The overcurrent run is broken one strobe short, so a non-consecutive count would trigger a premature restart.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int unsigned NUM_RAIL  = 5;
    localparam int unsigned CAUSE_ISO = 5;
    localparam int unsigned CAUSE_UV  = 6;
    localparam int unsigned NUM_CAUSE = 7;

    localparam int unsigned EN_BOOST = 0;
    localparam int unsigned EN_IO    = 1;
    localparam int unsigned EN_CORE  = 2;
    localparam int unsigned EN_GH    = 3;
    localparam int unsigned EN_GL    = 4;
    localparam int unsigned EN_ISO   = 5;
    localparam int unsigned NUM_EN   = 6;

    typedef enum logic [1:0] {
        FDIV_FULL    = 2'b00,
        FDIV_HALF    = 2'b01,
        FDIV_QUARTER = 2'b10
    } fdiv_e;

    typedef struct packed {
        logic                 armed;
        logic                 shutdown;
        logic [NUM_CAUSE-1:0] cause;
        logic [NUM_EN-1:0]    en;
        fdiv_e                fdiv;
    } sup_state_t;
endpackage

// File: rtl/rfs_persist.sv
module rfs_persist #(
    parameter int unsigned LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic active,
    output logic expire
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = active && tick && (cnt_q == LAST);
        if (clr || !active) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfs_hiccup.sv
module rfs_hiccup #(
    parameter int unsigned RUN_LEN    = 7,
    parameter int unsigned HOLD_TICKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic sw_cycle,
    input  logic oc,
    output logic busy_nx
);
    localparam int unsigned RW = $clog2(RUN_LEN + 1);
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
    localparam logic [RW-1:0] RUN_LAST  = RW'(RUN_LEN - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [RW-1:0] run_d, run_q;
    logic [HW-1:0] hold_d, hold_q;
    logic          busy_d, busy_q;

    always_comb begin
        run_d  = run_q;
        hold_d = hold_q;
        busy_d = busy_q;
        if (clr) begin
            run_d  = '0;
            hold_d = '0;
            busy_d = 1'b0;
        end else if (busy_q) begin
            run_d = '0;
            if (tick) begin
                if (hold_q == HOLD_LAST) begin
                    busy_d = 1'b0;
                    hold_d = '0;
                end else begin
                    hold_d = hold_q + 1'b1;
                end
            end
        end else if (sw_cycle) begin
            if (!oc) begin
                run_d = '0;
            end else if (run_q == RUN_LAST) begin
                run_d  = '0;
                hold_d = '0;
                busy_d = 1'b1;
            end else begin
                run_d = run_q + 1'b1;
            end
        end
        busy_nx = busy_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            hold_q <= '0;
            busy_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            hold_q <= hold_d;
            busy_q <= busy_d;
        end
    end
endmodule

// File: rtl/rail_fault_sup.sv
module rail_fault_sup
    import rfs_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 50000,
    parameter int unsigned SHORT_TICKS = 200,
    parameter int unsigned OC_CYCLES   = 7,
    parameter int unsigned CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              boost_low,
    input  logic              io_low,
    input  logic              io_short,
    input  logic              core_low,
    input  logic              core_short,
    input  logic              gh_low,
    input  logic              gl_high,
    input  logic              iso_over,
    input  logic [CODE_W-1:0] iso_code,
    input  logic              core_oc,
    input  logic              sw_cycle,
    input  logic              hot,
    input  logic              uv,
    input  logic              deep_rst,
    output logic              en_boost,
    output logic              en_iso,
    output logic              en_io,
    output logic              en_core,
    output logic              en_gh,
    output logic              en_gl,
    output logic [1:0]        io_fdiv,
    output logic              shutdown,
    output logic [6:0]        fault_cause
);
    sup_state_t s_d, s_q;

    logic [NUM_RAIL-1:0]  rail_flag;
    logic [NUM_RAIL-1:0]  rail_exp;
    logic                 iso_eff;
    logic                 iso_exp;
    logic                 hic_busy;
    logic [NUM_CAUSE-1:0] trip;
    logic                 run, conv;

    assign rail_flag = {gl_high, gh_low, core_low, io_low, boost_low};
    assign iso_eff   = iso_over && (iso_code != '0);

    for (genvar g = 0; g < NUM_RAIL; g++) begin : g_rail
        rfs_persist #(.LIMIT(LONG_TICKS)) rail_tmr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (deep_rst),
            .tick   (tick),
            .active (rail_flag[g]),
            .expire (rail_exp[g])
        );
    end

    rfs_persist #(.LIMIT(SHORT_TICKS)) iso_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (deep_rst),
        .tick   (tick),
        .active (iso_eff),
        .expire (iso_exp)
    );

    rfs_hiccup #(.RUN_LEN(OC_CYCLES), .HOLD_TICKS(LONG_TICKS)) hic_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (deep_rst),
        .tick     (tick),
        .sw_cycle (sw_cycle),
        .oc       (core_oc),
        .busy_nx  (hic_busy)
    );

    always_comb begin
        s_d  = s_q;
        trip = {uv && s_q.armed, iso_exp, rail_exp};

        if (deep_rst) begin
            s_d.armed    = 1'b0;
            s_d.shutdown = 1'b0;
            s_d.cause    = '0;
        end else begin
            s_d.armed    = s_q.armed || !uv;
            s_d.shutdown = s_q.shutdown || (|trip);
            s_d.cause    = s_q.cause | trip;
        end

        run  = s_d.armed && !s_d.shutdown;
        conv = run && !hot;

        s_d.en[EN_BOOST] = conv && !boost_low && !iso_eff;
        s_d.en[EN_IO]    = conv;
        s_d.en[EN_CORE]  = conv && !core_short && !hic_busy;
        s_d.en[EN_GH]    = conv && !gh_low;
        s_d.en[EN_GL]    = conv && !gl_high;
        s_d.en[EN_ISO]   = run && !iso_eff;

        if (io_short)    s_d.fdiv = FDIV_QUARTER;
        else if (io_low) s_d.fdiv = FDIV_HALF;
        else             s_d.fdiv = FDIV_FULL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.armed    <= 1'b0;
            s_q.shutdown <= 1'b0;
            s_q.cause    <= '0;
            s_q.en       <= '0;
            s_q.fdiv     <= FDIV_FULL;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_boost    = s_q.en[EN_BOOST];
    assign en_iso      = s_q.en[EN_ISO];
    assign en_io       = s_q.en[EN_IO];
    assign en_core     = s_q.en[EN_CORE];
    assign en_gh       = s_q.en[EN_GH];
    assign en_gl       = s_q.en[EN_GL];
    assign io_fdiv     = s_q.fdiv;
    assign shutdown    = s_q.shutdown;
    assign fault_cause = s_q.cause;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              deep_rst,
    input logic              hot,
    input logic              io_low,
    input logic              io_short,
    input logic [CODE_W-1:0] iso_code,
    input logic              en_boost,
    input logic              en_iso,
    input logic              en_io,
    input logic              en_core,
    input logic              en_gh,
    input logic              en_gl,
    input logic [1:0]        io_fdiv,
    input logic              shutdown,
    input logic [6:0]        fault_cause
);
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown && !deep_rst |=> shutdown);

    p_deep_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        deep_rst |=> !shutdown && fault_cause == '0);

    p_all_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !(en_boost || en_iso || en_io || en_core || en_gh || en_gl));

    p_hot_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> !(en_boost || en_io || en_core || en_gh || en_gl));

    p_cause_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $countones(fault_cause) >= 1);

    p_iso_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_code == '0) && !fault_cause[5] |=> !fault_cause[5]);

    p_fold_quarter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_short |=> io_fdiv == 2'b10);

    p_fold_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_low && !io_short |=> io_fdiv == 2'b01);

    p_fold_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_fdiv != 2'b11);
endmodule

bind rail_fault_sup rfs_checker #(.CODE_W(CODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .deep_rst    (deep_rst),
    .hot         (hot),
    .io_low      (io_low),
    .io_short    (io_short),
    .iso_code    (iso_code),
    .en_boost    (en_boost),
    .en_iso      (en_iso),
    .en_io       (en_io),
    .en_core     (en_core),
    .en_gh       (en_gh),
    .en_gl       (en_gl),
    .io_fdiv     (io_fdiv),
    .shutdown    (shutdown),
    .fault_cause (fault_cause)
);

// File: tb/rail_fault_sup_tb.sv
module rail_fault_sup_tb_top;
    localparam int LONG_T  = 6;
    localparam int SHORT_T = 3;
    localparam int OC_N    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, boost_low = 0, io_low = 0, io_short = 0, core_low = 0;
    logic core_short = 0, gh_low = 0, gl_high = 0, iso_over = 0;
    logic [3:0] iso_code = 4'd0;
    logic core_oc = 0, sw_cycle = 0, hot = 0, uv = 1, deep_rst = 0;
    logic en_boost, en_iso, en_io, en_core, en_gh, en_gl, shutdown;
    logic [1:0] io_fdiv;
    logic [6:0] fault_cause;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rail_fault_sup #(.LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T),
                     .OC_CYCLES(OC_N), .CODE_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .boost_low(boost_low),
        .io_low(io_low), .io_short(io_short), .core_low(core_low),
        .core_short(core_short), .gh_low(gh_low), .gl_high(gl_high),
        .iso_over(iso_over), .iso_code(iso_code), .core_oc(core_oc),
        .sw_cycle(sw_cycle), .hot(hot), .uv(uv), .deep_rst(deep_rst),
        .en_boost(en_boost), .en_iso(en_iso), .en_io(en_io),
        .en_core(en_core), .en_gh(en_gh), .en_gl(en_gl),
        .io_fdiv(io_fdiv), .shutdown(shutdown), .fault_cause(fault_cause)
    );

    function automatic logic [31:0] en_vec();
        return {26'd0, en_iso, en_gl, en_gh, en_core, en_io, en_boost};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic swc(input logic oc);
        @(negedge clk) begin sw_cycle = 1'b1; core_oc = oc; end
        @(negedge clk) begin sw_cycle = 1'b0; core_oc = 1'b0; end
    endtask

    task automatic set_rail(input int idx, input logic v);
        case (idx)
            0: boost_low = v;
            1: io_low    = v;
            2: core_low  = v;
            3: gh_low    = v;
            default: gl_high = v;
        endcase
    endtask

    task automatic deep_clear();
        deep_rst = 1'b1; uv = 1'b1;
        cyc(1);
        deep_rst = 1'b0; uv = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(3);
        chk("R1 reset enables", en_vec(), 32'h0);
        chk("R1 reset shutdown/cause/fdiv", {shutdown, fault_cause, io_fdiv}, 32'h0);
        rst_n = 1'b1;
        // R5 not armed: uv held high, no latch, no enables
        cyc(4);
        chk("R5 unarmed uv no latch", {shutdown, fault_cause}, 32'h0);
        chk("R1 enables wait for supply", en_vec(), 32'h0);
        uv = 1'b0;
        cyc(1);
        chk("R1 enables after supply good", en_vec(), 32'h3F);

        // R2/R3 per-rail windows, R6/R11 latch behaviour
        for (int idx = 0; idx < 5; idx++) begin
            logic [31:0] exp_en;
            exp_en = (idx == 0 || idx == 3 || idx == 4) ? (32'h3F & ~(32'h1 << idx)) : 32'h3F;
            set_rail(idx, 1'b1);
            cyc(1);
            chk($sformatf("R2 rail %0d enables", idx), en_vec(), exp_en);
            if (idx == 1) chk("R8 io_low half rate", io_fdiv, 32'h1);
            ticks(LONG_T - 1);
            chk($sformatf("R3 rail %0d one short", idx), shutdown, 32'h0);
            set_rail(idx, 1'b0);
            cyc(1);
            chk($sformatf("R2 rail %0d recovered", idx), en_vec(), 32'h3F);
            set_rail(idx, 1'b1);
            ticks(LONG_T - 1);
            chk($sformatf("R3 rail %0d restart after dropout", idx), shutdown, 32'h0);
            ticks(1);
            chk($sformatf("R3 rail %0d latched", idx), {shutdown, fault_cause}, 32'h80 | (32'h1 << idx));
            chk($sformatf("R11 rail %0d all off", idx), en_vec(), 32'h0);
            set_rail(idx, 1'b0);
            cyc(3);
            chk($sformatf("R6 rail %0d latch holds", idx), {shutdown, fault_cause}, 32'h80 | (32'h1 << idx));
            chk($sformatf("R11 rail %0d still off", idx), en_vec(), 32'h0);
            deep_clear();
            chk($sformatf("R6 rail %0d deep clear", idx), {shutdown, fault_cause}, 32'h0);
            chk($sformatf("R6 rail %0d enables back", idx), en_vec(), 32'h3F);
        end

        // R4 isolation threshold code sweep
        for (int c = 0; c < 16; c++) begin
            iso_code = 4'(c);
            iso_over = 1'b1;
            cyc(1);
            chk($sformatf("R4 code %0d enables", c), en_vec(), (c == 0) ? 32'h3F : 32'h1E);
            ticks(SHORT_T - 1);
            chk($sformatf("R4 code %0d one short", c), shutdown, 32'h0);
            ticks(1);
            chk($sformatf("R4 code %0d latch", c), {shutdown, fault_cause},
                (c == 0) ? 32'h0 : 32'hA0);
            iso_over = 1'b0;
            deep_clear();
        end
        iso_code = 4'd0;

        // R5 armed undervoltage
        uv = 1'b1;
        cyc(1);
        chk("R5 armed uv latch", {shutdown, fault_cause}, 32'hC0);
        chk("R11 uv all off", en_vec(), 32'h0);
        uv = 1'b0;
        cyc(2);
        chk("R6 uv latch holds", {shutdown, fault_cause}, 32'hC0);
        deep_clear();
        chk("R6 uv deep clear", {shutdown, fault_cause}, 32'h0);

        // R7 over-temperature
        hot = 1'b1;
        cyc(1);
        chk("R7 hot converters off", en_vec(), 32'h20);
        ticks(LONG_T + 2);
        chk("R7 hot no latch", {shutdown, fault_cause}, 32'h0);
        hot = 1'b0;
        cyc(1);
        chk("R7 hot recovery", en_vec(), 32'h3F);

        // R8 foldback sweep
        for (int m = 0; m < 4; m++) begin
            io_low = m[0];
            io_short = m[1];
            cyc(1);
            chk($sformatf("R8 foldback low=%0d short=%0d", m[0], m[1]), io_fdiv,
                m[1] ? 32'h2 : (m[0] ? 32'h1 : 32'h0));
            chk("R8 io stays enabled", en_io, 32'h1);
        end
        io_low = 1'b0; io_short = 1'b0;
        cyc(1);
        chk("R8 full rate restored", io_fdiv, 32'h0);

        // R9 core short
        core_short = 1'b1;
        cyc(1);
        chk("R9 core short stops core", en_vec(), 32'h3B);
        ticks(LONG_T + 1);
        chk("R9 core short no latch", shutdown, 32'h0);
        core_short = 1'b0;
        cyc(1);
        chk("R9 core short recovery", en_core, 32'h1);

        // R10 overcurrent run and restart
        for (int k = 0; k < OC_N - 1; k++) swc(1'b1);
        swc(1'b0);
        for (int k = 0; k < OC_N - 1; k++) swc(1'b1);
        chk("R10 broken run no restart", en_core, 32'h1);
        swc(1'b1);
        chk("R10 run triggers off", en_core, 32'h0);
        ticks(LONG_T - 1);
        chk("R10 hold one short", en_core, 32'h0);
        ticks(1);
        chk("R10 core restarts", en_core, 32'h1);
        chk("R10 no latch", {shutdown, fault_cause}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule